// File: doc/BRIEF.md
# Receive FIFO with Flow-Control Watermarks

This block buffers received bytes between a serial receiver and a host read port. Its usable capacity follows two mode inputs. With buffering disabled it behaves as a one-byte holding register. With buffering enabled it holds either 16 bytes (compatibility capacity) or 128 bytes (deep capacity). The live fill level is always visible as a count. A receive-data request rises once that level reaches a threshold that software can program to any value.

Out-of-band flow control is derived directly from the fill level. A hold-off state is set when the level reaches an upper watermark. It is released only when the level drains to a lower watermark, so the state has hysteresis. This state can gate an active-low request-to-send line and, optionally, an active-low data-terminal-ready line. A push that finds no room is discarded and raises a sticky overrun flag. A flush input empties the buffer in one cycle.

Top module: `rx_watermark_fifo`

## Requirements
- R1: Capacity is 16 entries when `fifo_en`=1 and `deep_mode`=0, and 128 entries when `fifo_en`=1 and `deep_mode`=1. A push that finds the buffer at capacity, with no pop in the same cycle, is discarded.
- R2: When `fifo_en`=0, capacity is 1 entry, and `rx_trig`, `fc_hi` and `fc_lo` are ignored. The request is high whenever the entry is occupied. Hold-off is set on an occupied entry and cleared on an empty one.
- R3: `level` is registered and changes at the clock edge that samples a push or pop. A simultaneous push and pop leaves it unchanged, including when the buffer is full.
- R4: Bytes leave in arrival order. `rd_data` shows the oldest byte while `empty`=0. A pop on an empty buffer is ignored.
- R5: `flush` sets `level` to 0 at the next edge. It overrides a push or pop in the same cycle.
- R6: A discarded push sets `overrun`, which stays set until a cycle with `status_rd`=1. If a discarding push and `status_rd` occur together, `overrun` is set.
- R7: `held_off` becomes 1 when the next level is at least `fc_hi`. It becomes 0 when the next level is at most `fc_lo`, and otherwise keeps its value. `rts_n` = NOT(`rts_sw` AND NOT(`auto_rts_en` AND `held_off`)).
- R8: `dtr_n` = NOT(`dtr_sw` AND NOT(`auto_dtr_en` AND `held_off`)).
- R9: `rx_req` is 1 when `level` is at least the effective trigger. The effective trigger is `rx_trig`, with 0 read as 1 and any value above capacity read as capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Write `wr_data` into the buffer |
| wr_data | input | 8 | Received byte |
| pop | input | 1 | Remove the oldest byte |
| rd_data | output | 8 | Oldest byte |
| flush | input | 1 | Empty the buffer |
| status_rd | input | 1 | Status read strobe, clears overrun |
| fifo_en | input | 1 | 1 = buffered, 0 = single holding register |
| deep_mode | input | 1 | 1 = 128-entry capacity, 0 = 16 |
| rx_trig | input | 8 | Receive request threshold |
| fc_hi | input | 8 | Upper flow-control watermark |
| fc_lo | input | 8 | Lower flow-control watermark |
| auto_rts_en | input | 1 | Gate `rts_n` with hold-off |
| auto_dtr_en | input | 1 | Gate `dtr_n` with hold-off |
| rts_sw | input | 1 | Software request-to-send (1 = assert) |
| dtr_sw | input | 1 | Software terminal-ready (1 = assert) |
| level | output | 8 | Current fill count |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level equals capacity |
| rx_req | output | 1 | Receive-data request |
| overrun | output | 1 | Sticky discarded-push flag |
| held_off | output | 1 | Flow-control hold-off state |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low terminal-ready |

## Verification
The hysteresis checks assume that `fc_lo` is below `fc_hi`. They also assume that neither watermark nor `fifo_en` changed in the previous cycle, since the hold-off register was evaluated against the earlier settings. The capacity check assumes that the mode inputs only shrink capacity while the buffer is empty. The stimulus therefore holds the watermarks steady while filling and draining, and it changes mode only right after a flush or a full drain.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [1:0] {
    CAP_SINGLE = 2'd0,
    CAP_COMPAT = 2'd1,
    CAP_DEEP   = 2'd2
  } cap_mode_e;
endpackage

// File: rtl/rxw_store.sv
module rxw_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (wr_en) wptr_d = bump(wptr_q);
      if (rd_en) rptr_d = bump(rptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
endmodule

// File: rtl/rxw_count.sv
module rxw_count #(
  parameter int LVLW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            flush,
  input  logic            status_rd,
  input  logic [LVLW-1:0] cap,
  output logic            do_push,
  output logic            do_pop,
  output logic [LVLW-1:0] level,
  output logic [LVLW-1:0] level_nxt,
  output logic            overrun
);
  logic [LVLW-1:0] level_q;
  logic            ovr_q, ovr_d, drop;

  always_comb begin
    do_pop  = pop & ~flush & (level_q != '0);
    do_push = push & ~flush & ((level_q < cap) | do_pop);
    drop    = push & ~flush & ~do_push;
    if (flush) level_nxt = '0;
    else       level_nxt = level_q + LVLW'(do_push) - LVLW'(do_pop);
    ovr_d = drop | (ovr_q & ~status_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      level_q <= level_nxt;
      ovr_q   <= ovr_d;
    end
  end

  assign level   = level_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/rxw_mark.sv
module rxw_mark #(
  parameter int LVLW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_en,
  input  logic [LVLW-1:0] level,
  input  logic [LVLW-1:0] level_nxt,
  input  logic [LVLW-1:0] cap,
  input  logic [LVLW-1:0] rx_trig,
  input  logic [LVLW-1:0] fc_hi,
  input  logic [LVLW-1:0] fc_lo,
  output logic            rx_req,
  output logic            hold
);
  logic [LVLW-1:0] trig_eff, hi_eff, lo_eff;
  logic            hold_q, hold_d;

  always_comb begin
    if (!fifo_en)              trig_eff = LVLW'(1);
    else if (rx_trig == '0)    trig_eff = LVLW'(1);
    else if (rx_trig > cap)    trig_eff = cap;
    else                       trig_eff = rx_trig;
    rx_req = (level >= trig_eff);

    hi_eff = fifo_en ? fc_hi : LVLW'(1);
    lo_eff = fifo_en ? fc_lo : '0;
    if (level_nxt >= hi_eff)      hold_d = 1'b1;
    else if (level_nxt <= lo_eff) hold_d = 1'b0;
    else                          hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold = hold_q;
endmodule

// File: rtl/rx_watermark_fifo.sv
module rx_watermark_fifo #(
  parameter int DW           = 8,
  parameter int DEEP_DEPTH   = 128,
  parameter int COMPAT_DEPTH = 16,
  parameter bit DTR_EN       = 1'b1,
  localparam int LVLW        = $clog2(DEEP_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   wr_data,
  input  logic            pop,
  output logic [DW-1:0]   rd_data,
  input  logic            flush,
  input  logic            status_rd,
  input  logic            fifo_en,
  input  logic            deep_mode,
  input  logic [LVLW-1:0] rx_trig,
  input  logic [LVLW-1:0] fc_hi,
  input  logic [LVLW-1:0] fc_lo,
  input  logic            auto_rts_en,
  input  logic            auto_dtr_en,
  input  logic            rts_sw,
  input  logic            dtr_sw,
  output logic [LVLW-1:0] level,
  output logic            empty,
  output logic            full,
  output logic            rx_req,
  output logic            overrun,
  output logic            held_off,
  output logic            rts_n,
  output logic            dtr_n
);
  import rxw_pkg::*;

  cap_mode_e       mode;
  logic [LVLW-1:0] cap, level_nxt;
  logic            do_push, do_pop, hold;

  always_comb begin
    if (!fifo_en)      mode = CAP_SINGLE;
    else if (deep_mode) mode = CAP_DEEP;
    else               mode = CAP_COMPAT;
    case (mode)
      CAP_DEEP:   cap = LVLW'(DEEP_DEPTH);
      CAP_COMPAT: cap = LVLW'(COMPAT_DEPTH);
      default:    cap = LVLW'(1);
    endcase
  end

  rxw_count #(.LVLW(LVLW)) u_count (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .status_rd(status_rd), .cap(cap), .do_push(do_push), .do_pop(do_pop),
    .level(level), .level_nxt(level_nxt), .overrun(overrun)
  );

  rxw_store #(.DW(DW), .DEPTH(DEEP_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(do_push), .rd_en(do_pop),
    .clr(flush), .wdata(wr_data), .rdata(rd_data)
  );

  rxw_mark #(.LVLW(LVLW)) u_mark (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .level(level),
    .level_nxt(level_nxt), .cap(cap), .rx_trig(rx_trig), .fc_hi(fc_hi),
    .fc_lo(fc_lo), .rx_req(rx_req), .hold(hold)
  );

  assign empty    = (level == '0);
  assign full     = (level == cap);
  assign held_off = hold;
  assign rts_n    = ~(rts_sw & ~(auto_rts_en & hold));

  generate
    if (DTR_EN) begin : g_dtr_auto
      assign dtr_n = ~(dtr_sw & ~(auto_dtr_en & hold));
    end else begin : g_dtr_plain
      logic unused_dtr_en;
      assign unused_dtr_en = auto_dtr_en;
      assign dtr_n = ~dtr_sw;
    end
  endgenerate
endmodule

// File: rtl/rxw_chk.sv
module rxw_chk #(
  parameter int LVLW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            status_rd,
  input logic            fifo_en,
  input logic [LVLW-1:0] level,
  input logic [LVLW-1:0] cap,
  input logic [LVLW-1:0] fc_hi,
  input logic [LVLW-1:0] fc_lo,
  input logic            overrun,
  input logic            held_off,
  input logic            auto_rts_en,
  input logic            rts_n
);
  // R1
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= cap);

  // R3
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ((level == $past(level)) || (level == $past(level) + 1'b1) ||
                ($past(level) == level + 1'b1)));

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !status_rd) |=> overrun);

  // R7
  hold_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && $stable(fifo_en) && $stable(fc_hi) && level >= fc_hi) |-> held_off);

  // R7
  hold_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && $stable(fifo_en) && $stable(fc_hi) && $stable(fc_lo) &&
     fc_lo < fc_hi && level <= fc_lo) |-> !held_off);

  // R7
  rts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && held_off) |-> rts_n);
endmodule

bind rx_watermark_fifo rxw_chk #(.LVLW(LVLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .status_rd(status_rd),
  .fifo_en(fifo_en), .level(level), .cap(cap), .fc_hi(fc_hi), .fc_lo(fc_lo),
  .overrun(overrun), .held_off(held_off), .auto_rts_en(auto_rts_en),
  .rts_n(rts_n)
);

// File: tb/sim_rx_watermark_fifo.sv
module sim_rx_watermark_fifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       push, pop, flush, status_rd;
  logic [7:0] wr_data, rd_data;
  logic       fifo_en, deep_mode;
  logic [7:0] rx_trig, fc_hi, fc_lo;
  logic       auto_rts_en, auto_dtr_en, rts_sw, dtr_sw;
  logic [7:0] level;
  logic       empty, full, rx_req, overrun, held_off, rts_n, dtr_n;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_watermark_fifo u0 (.*);

  typedef struct packed {
    logic       p;
    logic       q;
    logic       f;
    logic [7:0] d;
    logic [7:0] lvl;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b0, 1'b0, 8'hA1, 8'd1},
    '{1'b1, 1'b0, 1'b0, 8'hB2, 8'd2},
    '{1'b1, 1'b0, 1'b0, 8'hC3, 8'd3},
    '{1'b1, 1'b1, 1'b0, 8'h44, 8'd3},
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'd2},
    '{1'b1, 1'b0, 1'b1, 8'h99, 8'd0},
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'd0},
    '{1'b1, 1'b0, 1'b0, 8'h55, 8'd1},
    '{1'b1, 1'b1, 1'b0, 8'h66, 8'd1},
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'd0},
    '{1'b1, 1'b0, 1'b0, 8'h77, 8'd1},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic q, input logic f,
                       input logic s, input logic [7:0] d);
    @(negedge clk);
    push = p; pop = q; flush = f; status_rd = s; wr_data = d;
    @(posedge clk);
    #1;
    push = 1'b0; pop = 1'b0; flush = 1'b0; status_rd = 1'b0;
  endtask

  task automatic push_n(input int n, input int base);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 8'(base + i));
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; push = 0; pop = 0; flush = 0; status_rd = 0; wr_data = 0;
    fifo_en = 1; deep_mode = 0; rx_trig = 3; fc_hi = 10; fc_lo = 2;
    auto_rts_en = 0; auto_dtr_en = 0; rts_sw = 1; dtr_sw = 1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R3 reset level", level, 0);
    chk("R4 reset empty", empty, 1);
    chk("R6 reset overrun", overrun, 0);
    chk("R7 reset held_off", held_off, 0);
    chk("R7 reset rts_n", rts_n, 0);
    chk("R8 reset dtr_n", dtr_n, 0);
    chk("R9 reset rx_req", rx_req, 0);

    // vector table: level after each step (R3, flush rows R5)
    foreach (VEC[i]) begin
      drive(VEC[i].p, VEC[i].q, VEC[i].f, 1'b0, VEC[i].d);
      chk(VEC[i].f ? "R5 table level" : "R3 table level", level, VEC[i].lvl);
    end

    // R4 order and empty pop
    push_n(3, 8'h11);
    chk("R4 head first", rd_data, 8'h11);
    pop_n(1);
    chk("R4 head second", rd_data, 8'h12);
    pop_n(1);
    chk("R4 head third", rd_data, 8'h13);
    pop_n(2);
    chk("R4 pop on empty level", level, 0);
    chk("R4 pop on empty flag", empty, 1);

    // R1 compat capacity, R6 overrun
    push_n(20, 8'h20);
    chk("R1 compat level", level, 16);
    chk("R1 compat full", full, 1);
    chk("R6 overrun set", overrun, 1);
    chk("R1 oldest kept", rd_data, 8'h20);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R6 overrun cleared", overrun, 0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'hEE);
    chk("R3 push+pop at full level", level, 16);
    chk("R3 push+pop at full no overrun", overrun, 0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hEF);
    chk("R6 set wins over clear", overrun, 1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R5 flush from full", level, 0);

    // R1 deep capacity
    deep_mode = 1;
    push_n(130, 0);
    chk("R1 deep level", level, 128);
    chk("R1 deep overrun", overrun, 1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R5 flush deep", level, 0);

    // R2 single holding register
    deep_mode = 0; fifo_en = 0; auto_rts_en = 1;
    push_n(1, 8'h5A);
    chk("R2 single level", level, 1);
    chk("R2 single rx_req with trig ignored", rx_req, 1);
    chk("R2 single held_off", held_off, 1);
    chk("R7 rts_n held in single", rts_n, 1);
    push_n(1, 8'h5B);
    chk("R2 single second push dropped", level, 1);
    chk("R2 single overrun", overrun, 1);
    chk("R2 single data kept", rd_data, 8'h5A);
    pop_n(1);
    chk("R2 single release", held_off, 0);
    chk("R7 rts_n released single", rts_n, 0);
    fifo_en = 1;
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);

    // R7 hysteresis, R8 DTR
    fc_hi = 6; fc_lo = 2;
    push_n(5, 8'h30);
    chk("R7 below upper rts_n", rts_n, 0);
    push_n(1, 8'h35);
    chk("R7 at upper held_off", held_off, 1);
    chk("R7 at upper rts_n", rts_n, 1);
    chk("R8 dtr ungated", dtr_n, 0);
    pop_n(3);
    chk("R7 between marks held", rts_n, 1);
    pop_n(1);
    chk("R7 at lower released", rts_n, 0);
    rts_sw = 0;
    #1 chk("R7 software deassert", rts_n, 1);
    rts_sw = 1;
    auto_dtr_en = 1;
    push_n(4, 8'h40);
    chk("R8 dtr held", dtr_n, 1);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R5 flush releases held_off", held_off, 0);
    chk("R8 dtr released", dtr_n, 0);

    // R9 programmable trigger
    rx_trig = 5;
    push_n(4, 8'h50);
    chk("R9 below trig", rx_req, 0);
    push_n(1, 8'h54);
    chk("R9 at trig", rx_req, 1);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    push_n(1, 8'h60);
    rx_trig = 0;
    #1 chk("R9 trig zero as one", rx_req, 1);
    rx_trig = 2;
    #1 chk("R9 trig two at level one", rx_req, 0);
    rx_trig = 200; fc_hi = 100; fc_lo = 50;
    push_n(15, 8'h61);
    chk("R9 trig clamped to capacity", rx_req, 1);

    finish_run();
  end
endmodule